// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the addressing layer of a slave device on a single-wire bus. Every slave carries a 64-bit identity. A bit-level engine below this layer turns bus waveforms into single-cycle strobes: one for a detected bus reset (with a flag that marks a long reset), one for each write slot (with the received bit), and one for each read slot. For each read slot the layer supplies the bit the engine should drive.

After every bus reset the layer collects an eight-bit command and carries it out. Read sends the identity out. Match compares the identity against bits sent by the master. Search runs the bus arbitration walk. Skip selects the device without addressing it. Two further commands switch the bus to the fast rate: a skip variant and a match variant. The layer holds the overdrive flag that sets the engine's bit rate. It raises a registered `selected` output when the memory layer above may take over the bus.

The identity is built from parameters when the design is elaborated. The low byte is the family code 0x0F, followed by a 48-bit serial number. The top byte is a CRC computed over those first 56 bits with the polynomial x^8+x^5+x^4+1, starting from zero and taking the least significant bit first.

Top module: `swRomLayer`

## Requirements
- R1: After the system reset `selected` is 0, `overdrive` is 0 and `rdBit` is 1. Until the first bus-reset strobe, all slots are ignored, so even a complete Skip byte does not select the device.
- R2: Command 0x33, received least significant bit first, makes the next 64 read slots return the identity least significant bit first: family 0x0F in bits 7:0, the serial number in bits 55:8 and the CRC in bits 63:56. Shifting all 64 bits through the CRC gives zero. `selected` rises after the 64th read slot.
- R3: Command 0x55 compares the next 64 write-slot bits against the identity. If all of them are equal, `selected` rises after the 64th bit. On the first unequal bit the layer ignores every slot until the next bus reset: `rdBit` stays 1 and `selected` stays 0.
- R4: Command 0xF0 handles each identity bit in three slots: a read slot returns the bit, a second read slot returns its complement, and a write slot takes the master's chosen bit. If the chosen bit differs from the identity bit, the device drops out until the next bus reset and reads return 1. If all 64 bits agree, `selected` rises.
- R5: Command 0xCC sets `selected` in the cycle after the eighth command bit. While `selected` is 1, read slots return 1, and `selected` stays at 1 until the next bus reset.
- R6: Command 0x3C sets both `overdrive` and `selected` in the cycle after the eighth command bit.
- R7: Command 0x69 sets `overdrive` right after the command byte, and then runs the 64-bit match. On success `selected` rises and `overdrive` stays 1. On a mismatch `overdrive` goes back to the value it had before the command.
- R8: Every bus-reset strobe clears `selected` and restarts command reception. A long reset (`resetLong`=1) clears `overdrive`. A short reset leaves `overdrive` unchanged.
- R9: A command byte outside the six codes above makes the layer ignore all slots until the next bus reset. A following valid command byte is not decoded, and reads return 1.
- R10: When a bus-reset strobe and a slot strobe come in the same cycle, the reset takes effect and the slot is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| busReset | input | 1 | One-cycle strobe: bit engine saw a bus reset pulse |
| resetLong | input | 1 | Qualifies busReset: the pulse was long enough to leave fast rate |
| wrSlot | input | 1 | One-cycle strobe: a write slot completed |
| wrBit | input | 1 | Bit received in the write slot |
| rdSlot | input | 1 | One-cycle strobe: a read slot is being served |
| rdBit | output | 1 | Bit to drive in the current read slot (1 means release) |
| overdrive | output | 1 | Fast bit rate is in force |
| selected | output | 1 | ROM phase completed; memory layer owns the bus |

## Verification
A bus-reset strobe can fall in the same cycle as the write slot that carries the last bit of a command. In that cycle the reset logic would restart command reception, and the command decoder would select the device or change the overdrive flag. The bench provokes this by sending seven bits of a Skip byte and then raising the eighth write slot together with the reset strobe. The result is judged correct when `selected` stays low and a complete Skip byte sent afterwards selects the device, which shows that the discarded bit left no partial command behind.

// File: rtl/swRomPkg.sv
package swRomPkg;

  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_READ     = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH    = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SEARCH   = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_SKIP     = 8'hCC;
  localparam logic [CMD_W-1:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [CMD_W-1:0] CMD_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SEARCH,
    ST_SEL
  } romState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic cmdShift;
    logic phClr;
    logic phInc;
  } pathCtl_t;

  // identity check byte, x^8+x^5+x^4+1, reflected, lsb first, seed zero
  function automatic logic [7:0] idCrc8(input logic [127:0] d, input int n);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < 128; i++) begin
      if (i < n) begin
        fb = c[0] ^ d[i];
        c  = {1'b0, c[7:1]};
        if (fb) c = c ^ 8'h8C;
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/swRomPath.sv
module swRomPath
  import swRomPkg::*;
#(
  parameter int              ID_W   = 64,
  parameter logic [ID_W-1:0] ID_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrBit,
  input  pathCtl_t         ctl,
  output logic             idBit,
  output logic             cntLast,
  output logic             cmdLast,
  output logic [CMD_W-1:0] cmdNext,
  output logic [1:0]       phase
);

  localparam int CNT_W = $clog2(ID_W);

  logic [CNT_W-1:0] bitIdx;
  logic [CMD_W-1:0] cmdReg;

  // one index serves both the command byte and the identity walk
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           bitIdx <= '0;
    else if (ctl.cntClr) bitIdx <= '0;
    else if (ctl.cntInc) bitIdx <= bitIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cmdReg <= '0;
    else if (ctl.cmdShift) cmdReg <= cmdNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          phase <= 2'd0;
    else if (ctl.phClr) phase <= 2'd0;
    else if (ctl.phInc) phase <= phase + 2'd1;
  end

  assign cmdNext = {wrBit, cmdReg[CMD_W-1:1]};
  assign idBit   = ID_VAL[bitIdx];
  assign cntLast = (bitIdx == CNT_W'(ID_W - 1));
  assign cmdLast = (bitIdx == CNT_W'(CMD_W - 1));

endmodule

// File: rtl/swRomCtrl.sv
module swRomCtrl
  import swRomPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             resetLong,
  input  logic             wrSlot,
  input  logic             wrBit,
  input  logic             rdSlot,
  input  logic             idBit,
  input  logic             cntLast,
  input  logic             cmdLast,
  input  logic [CMD_W-1:0] cmdNext,
  input  logic [1:0]       phase,
  output pathCtl_t         ctl,
  output logic             rdBit,
  output logic             overdrive,
  output logic             selected
);

  romState_t st;
  logic      odPrev;
  logic      odMatch;
  logic      cmdDone;

  assign cmdDone = wrSlot && cmdLast;

  always_comb begin
    ctl   = '0;
    rdBit = 1'b1;
    case (st)
      ST_CMD: begin
        if (wrSlot) begin
          ctl.cmdShift = 1'b1;
          if (cmdLast) begin
            ctl.cntClr = 1'b1;
            ctl.phClr  = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
      end
      ST_READ: begin
        rdBit = idBit;
        if (rdSlot) ctl.cntInc = 1'b1;
      end
      ST_MATCH: begin
        if (wrSlot) ctl.cntInc = 1'b1;
      end
      ST_SEARCH: begin
        if (phase == 2'd0)      rdBit = idBit;
        else if (phase == 2'd1) rdBit = ~idBit;
        if (rdSlot && phase != 2'd2) ctl.phInc = 1'b1;
        if (wrSlot && phase == 2'd2) begin
          ctl.phClr  = 1'b1;
          ctl.cntInc = 1'b1;
        end
      end
      default: ;
    endcase
    if (busReset) begin
      ctl        = '0;
      ctl.cntClr = 1'b1;
      ctl.phClr  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      overdrive <= 1'b0;
      selected  <= 1'b0;
      odPrev    <= 1'b0;
      odMatch   <= 1'b0;
    end else if (busReset) begin
      st       <= ST_CMD;
      selected <= 1'b0;
      if (resetLong) overdrive <= 1'b0;
    end else begin
      case (st)
        ST_CMD: begin
          if (cmdDone) begin
            case (cmdNext)
              CMD_READ:   st <= ST_READ;
              CMD_SEARCH: st <= ST_SEARCH;
              CMD_MATCH: begin
                st      <= ST_MATCH;
                odMatch <= 1'b0;
              end
              CMD_OD_MATCH: begin
                st        <= ST_MATCH;
                odMatch   <= 1'b1;
                odPrev    <= overdrive;
                overdrive <= 1'b1;
              end
              CMD_SKIP: begin
                st       <= ST_SEL;
                selected <= 1'b1;
              end
              CMD_OD_SKIP: begin
                st        <= ST_SEL;
                selected  <= 1'b1;
                overdrive <= 1'b1;
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
        ST_READ: begin
          if (rdSlot && cntLast) begin
            st       <= ST_SEL;
            selected <= 1'b1;
          end
        end
        ST_MATCH: begin
          if (wrSlot) begin
            if (wrBit != idBit) begin
              st <= ST_IDLE;
              if (odMatch) overdrive <= odPrev;
            end else if (cntLast) begin
              st       <= ST_SEL;
              selected <= 1'b1;
            end
          end
        end
        ST_SEARCH: begin
          if (wrSlot && phase == 2'd2) begin
            if (wrBit != idBit) begin
              st <= ST_IDLE;
            end else if (cntLast) begin
              st       <= ST_SEL;
              selected <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/swRomLayer.sv
module swRomLayer
  import swRomPkg::*;
#(
  parameter int               SER_W  = 48,
  parameter logic [SER_W-1:0] SERIAL = 48'h5A3C_9E12_D7B4,
  parameter logic [7:0]       FAMILY = 8'h0F
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReset,
  input  logic resetLong,
  input  logic wrSlot,
  input  logic wrBit,
  input  logic rdSlot,
  output logic rdBit,
  output logic overdrive,
  output logic selected
);

  localparam int              BODY_W = SER_W + 8;
  localparam int              ID_W   = BODY_W + 8;
  localparam logic [7:0]      ID_CRC = idCrc8(128'({SERIAL, FAMILY}), BODY_W);
  localparam logic [ID_W-1:0] ID_VAL = {ID_CRC, SERIAL, FAMILY};

  pathCtl_t         ctl;
  logic             idBit;
  logic             cntLast;
  logic             cmdLast;
  logic [CMD_W-1:0] cmdNext;
  logic [1:0]       phase;

  swRomCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .busReset(busReset), .resetLong(resetLong),
    .wrSlot(wrSlot), .wrBit(wrBit), .rdSlot(rdSlot), .idBit(idBit),
    .cntLast(cntLast), .cmdLast(cmdLast), .cmdNext(cmdNext), .phase(phase),
    .ctl(ctl), .rdBit(rdBit), .overdrive(overdrive), .selected(selected)
  );

  swRomPath #(.ID_W(ID_W), .ID_VAL(ID_VAL)) path_i (
    .clk(clk), .rstN(rstN), .wrBit(wrBit), .ctl(ctl), .idBit(idBit),
    .cntLast(cntLast), .cmdLast(cmdLast), .cmdNext(cmdNext), .phase(phase)
  );

endmodule

// File: rtl/swRomLayerChk.sv
module swRomLayerChk (
  input logic clk,
  input logic rstN,
  input logic busReset,
  input logic resetLong,
  input logic wrSlot,
  input logic rdBit,
  input logic overdrive,
  input logic selected
);

  p_sel_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !selected);

  p_od_long_r8: assert property (@(posedge clk) disable iff (!rstN)
    busReset && resetLong |=> !overdrive);

  p_od_short_r8: assert property (@(posedge clk) disable iff (!rstN)
    busReset && !resetLong |=> overdrive == $past(overdrive));

  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    selected && !busReset |=> selected);

  p_sel_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> rdBit);

  p_od_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overdrive) |-> $past(wrSlot) && !$past(busReset));

  p_slot_lost_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReset && wrSlot |=> !selected && !$rose(overdrive));

endmodule

bind swRomLayer swRomLayerChk chk_i (
  .clk(clk), .rstN(rstN), .busReset(busReset), .resetLong(resetLong),
  .wrSlot(wrSlot), .rdBit(rdBit), .overdrive(overdrive), .selected(selected)
);

// File: tb/swRomLayer_tb_top.sv
module swRomLayer_tb_top;

  localparam logic [47:0] SER = 48'h9B17_40E2_C65D;
  localparam logic [7:0]  FAM = 8'h0F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0, resetLong = 1'b0;
  logic wrSlot = 1'b0, wrBit = 1'b0, rdSlot = 1'b0;
  logic rdBit, overdrive, selected;

  int total = 0;
  int bad = 0;
  logic [63:0] expId;
  logic expOd;

  always #2 clk = ~clk;

  swRomLayer #(.SER_W(48), .SERIAL(SER), .FAMILY(FAM)) dut_i (
    .clk(clk), .rstN(rstN), .busReset(busReset), .resetLong(resetLong),
    .wrSlot(wrSlot), .wrBit(wrBit), .rdSlot(rdSlot),
    .rdBit(rdBit), .overdrive(overdrive), .selected(selected)
  );

  // bench CRC: shift register form, feedback taps for x^8+x^5+x^4+1
  function automatic logic [7:0] crcRun(input logic [63:0] d, input int n);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic f = s[0] ^ d[i];
      s = s >> 1;
      s[7] = f;
      s[3] = s[3] ^ f;
      s[2] = s[2] ^ f;
    end
    return s;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrS(input logic b);
    @(negedge clk); wrSlot = 1'b1; wrBit = b;
    @(negedge clk); wrSlot = 1'b0;
  endtask

  task automatic rdS(output logic b);
    @(negedge clk); rdSlot = 1'b1; b = rdBit;
    @(negedge clk); rdSlot = 1'b0;
  endtask

  task automatic busRst(input logic lng);
    @(negedge clk); busReset = 1'b1; resetLong = lng;
    @(negedge clk); busReset = 1'b0; resetLong = 1'b0;
    if (lng) expOd = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) wrS(b[i]);
  endtask

  // flip < 0 means the full identity is sent unchanged
  task automatic doMatch(input logic [7:0] cmd, input int flip, input string req);
    logic odBefore = expOd;
    sendByte(cmd);
    if (cmd == 8'h69) chk({req, " od after cmd"}, overdrive, 1);
    for (int i = 0; i < 64; i++) wrS(expId[i] ^ (i == flip));
    if (cmd == 8'h69) expOd = (flip < 0) ? 1'b1 : odBefore;
    chk({req, " selected"}, selected, flip < 0);
    chk({req, " overdrive"}, overdrive, expOd);
  endtask

  task automatic doSearch(input int flip, input string req);
    logic a, b, gone;
    gone = 1'b0;
    sendByte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      rdS(a); rdS(b);
      if (gone) chk({req, " dropped reads"}, {a, b}, 2'b11);
      else      chk({req, " bit pair"}, {a, b}, {expId[i], ~expId[i]});
      wrS(expId[i] ^ (i == flip));
      if (i == flip) gone = 1'b1;
    end
    chk({req, " selected"}, selected, flip < 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic b;
    logic [63:0] got;
    void'($urandom(32'd20417));
    expId = {crcRun({SER, FAM}, 56), SER, FAM};
    expOd = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1
    chk("R1 selected", selected, 0);
    chk("R1 overdrive", overdrive, 0);
    chk("R1 rdBit", rdBit, 1);
    sendByte(8'hCC);
    rdS(b);
    chk("R1 no bus reset yet sel", selected, 0);
    chk("R1 no bus reset yet rd", b, 1);

    // R2
    busRst(1'b1);
    sendByte(8'h33);
    for (int i = 0; i < 64; i++) begin rdS(b); got[i] = b; end
    chk("R2 identity", got, expId);
    chk("R2 family", got[7:0], 8'h0F);
    chk("R2 crc residue", crcRun(got, 64), 0);
    chk("R2 selected", selected, 1);
    rdS(b);
    chk("R5 read while selected", b, 1);

    // R3
    busRst(1'b1);
    doMatch(8'h55, -1, "R3 full");
    busRst(1'b1);
    doMatch(8'h55, 17, "R3 mismatch");
    rdS(b);
    chk("R3 idle read", b, 1);

    // R4
    busRst(1'b1);
    doSearch(-1, "R4 full");
    busRst(1'b1);
    doSearch(40, "R4 drop");

    // R5
    busRst(1'b1);
    sendByte(8'hCC);
    chk("R5 skip selected", selected, 1);
    chk("R5 skip od", overdrive, 0);

    // R8 / R6
    busRst(1'b0);
    chk("R8 short reset clears sel", selected, 0);
    sendByte(8'h3C);
    expOd = 1'b1;
    chk("R6 od skip od", overdrive, 1);
    chk("R6 od skip sel", selected, 1);
    busRst(1'b0);
    chk("R8 short keeps od", overdrive, 1);
    busRst(1'b1);
    chk("R8 long clears od", overdrive, 0);

    // R7
    busRst(1'b1);
    doMatch(8'h69, 5, "R7 fail from regular");
    busRst(1'b1);
    doMatch(8'h69, -1, "R7 success");
    busRst(1'b0);
    doMatch(8'h69, 63, "R7 fail keeps od");

    // R9
    busRst(1'b1);
    sendByte(8'hA5);
    sendByte(8'hCC);
    rdS(b);
    chk("R9 unknown cmd sel", selected, 0);
    chk("R9 unknown cmd rd", b, 1);

    // R10: reset and last command bit in the same cycle
    busRst(1'b1);
    for (int i = 0; i < 7; i++) wrS(1'((8'hCC >> i) & 1));
    @(negedge clk); busReset = 1'b1; resetLong = 1'b1; wrSlot = 1'b1; wrBit = 1'b1;
    @(negedge clk); busReset = 1'b0; resetLong = 1'b0; wrSlot = 1'b0;
    chk("R10 slot discarded", selected, 0);
    sendByte(8'hCC);
    chk("R10 fresh command", selected, 1);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int op = int'($urandom % 4);
      int flip = ($urandom % 3 == 0) ? -1 : int'($urandom % 64);
      busRst(1'($urandom % 2));
      chk("R8 random reset od", overdrive, expOd);
      case (op)
        0: doMatch(8'h55, flip, "R3 random");
        1: doSearch(flip, "R4 random");
        2: doMatch(8'h69, flip, "R7 random");
        default: begin
          sendByte(8'h3C);
          expOd = 1'b1;
          chk("R6 random sel", selected, 1);
          chk("R6 random od", overdrive, 1);
        end
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule